// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical 4-bit slices that share one clock. Every state change happens on the rising clock edge. The slices advance together, so the whole register reads as one wide binary value. Three operations set the next value, in fixed priority. An active-low clear forces zero. An active-low parallel load copies the data input. Counting adds one, but only when both count-enable inputs are high.

The two enables do different jobs. `cnt_en` gates the increment only. `carry_en` gates the increment and also the terminal-carry output, so a second block can take that output as its own `carry_en` and extend the width without extra gates. Inside the block the same rule chains the slices: each slice receives the carry of the slice below it as its carry enable. A parameter chooses how that internal carry is formed. One option is a serial chain through the slices. The other is a parallel look-ahead AND of the lower slices' terminal flags.

A typical use shortens the count length. External logic decodes the terminal value from `q` and drives `clr_n` low on that value, so the counter restarts at zero on the next edge.

Top module: `casc_count`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` becomes 0 on that edge, whatever `load_n`, `cnt_en`, `carry_en` and `din` are.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` on that edge, whatever the enables are.
- R3: When `clr_n` and `load_n` are high and both `cnt_en` and `carry_en` are high, `q` increases by one on the edge.
- R4: An increment from the all-ones value wraps `q` to 0. No other flag records the overflow.
- R5: When `clr_n` and `load_n` are high and either enable is low, `q` holds its value.
- R6: `carry_out` is high exactly while `q` is all ones and `carry_en` is high. It follows `carry_en` combinationally, with no clock edge needed.
- R7: Changes on `clr_n`, `load_n`, `cnt_en`, `carry_en` or `din` between rising edges leave `q` unchanged until the next rising edge.
- R8: Slice k (bits 4k+3..4k) advances only when all lower slices are at 15 and both enables are high, so `q` as a whole counts in plain binary across slice boundaries.
- R9: If `clr_n` is driven as the active-low decode of `q` equal to 9, the count cycles 0 through 9 and restarts at 0 on the edge after 9.
- R10: Loading 0xFC and then counting gives 0xFD, 0xFE, 0xFF, 0x00, 0x01, 0x02, with `carry_out` high only in the 0xFF state. Lowering `cnt_en` then freezes `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all slices |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable that gates the increment only |
| carry_en | input | 1 | Count enable that also gates `carry_out` |
| din | input | STAGE_W*STAGES (8) | Parallel load data |
| q | output | STAGE_W*STAGES (8) | Current count |
| carry_out | output | 1 | Terminal carry for chaining to a further counter |

## Verification
The bench goes after the priority corners, where clear, load and count requests arrive on the same edge. A design that let load or an enable override clear would leave a nonzero value, and one that let the enables gate the load would miss the preset. Every one of the 256 values is loaded and then stepped under all four enable combinations. This exposes a wrong wrap at all-ones, a slice that advances without the lower slices' carry (a jump of 16 at a nibble boundary), and a hold that leaks a count when only one enable is high.

The carry output is checked between edges right after `carry_en` changes. A registered carry would then show one cycle late, and a carry that ignored `carry_en` would show up here too. The terminal-decode clear loop must repeat 0 to 9, so a clear that acted asynchronously would skip the 9 state.

// File: rtl/casc_pkg.sv
`timescale 1ns/1ps
package casc_pkg;

   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STEP  = 2'd2,
      OP_HOLD  = 2'd3
   } slice_op_e;

   // fixed priority: clear, then load, then step
   function automatic slice_op_e pick_op(input logic clr_n, input logic load_n,
                                         input logic step_ok);
      if (!clr_n)       return OP_CLEAR;
      else if (!load_n) return OP_LOAD;
      else if (step_ok) return OP_STEP;
      else              return OP_HOLD;
   endfunction

endpackage

// File: rtl/casc_carry.sv
`timescale 1ns/1ps
module casc_carry #(
   parameter int STAGES    = 2,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic              carry_en,
   input  logic [STAGES-1:0] term,
   output logic [STAGES-1:0] slice_en,
   output logic              carry_out
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("casc_carry: STAGES must be at least 1");
      end

      if (LOOKAHEAD) begin : g_look
         // each slice enable is a flat AND of all lower terminal flags
         for (genvar k = 0; k < STAGES; k++) begin : g_slice
            if (k == 0) begin : g_first
               assign slice_en[k] = carry_en;
            end else begin : g_upper
               assign slice_en[k] = carry_en & (&term[k-1:0]);
            end
         end
         assign carry_out = carry_en & (&term);
      end else begin : g_ripple
         // serial chain: each slice's carry feeds the next
         logic [STAGES:0] chain;
         assign chain[0] = carry_en;
         for (genvar k = 0; k < STAGES; k++) begin : g_slice
            assign slice_en[k]  = chain[k];
            assign chain[k+1]   = chain[k] & term[k];
         end
         assign carry_out = chain[STAGES];
      end
   endgenerate

endmodule

// File: rtl/casc_stage.sv
`timescale 1ns/1ps
module casc_stage
   import casc_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         load_n,
   input  logic         cnt_en,
   input  logic         slice_en,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         term
);

   localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

   generate
      if (W < 1) begin : g_bad_width
         $error("casc_stage: W must be at least 1");
      end
   endgenerate

   slice_op_e op;
   logic [W-1:0] cnt_r;

   always_comb op = pick_op(clr_n, load_n, cnt_en & slice_en);

   always_ff @(posedge clk) begin
      unique case (op)
         OP_CLEAR: cnt_r <= '0;
         OP_LOAD:  cnt_r <= din;
         OP_STEP:  cnt_r <= cnt_r + 1'b1;
         default:  cnt_r <= cnt_r;
      endcase
   end

   assign q    = cnt_r;
   assign term = (cnt_r == TOP_VAL);

   // checks armed once a clear has defined the state
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= armed | ~clr_n;

   a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
      (!clr_n) |=> (q == '0));
   a_r2_load: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !load_n) |=> (q == $past(din)));
   a_r3_step: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en && slice_en) |=> (q == W'($past(q) + 1'b1)));
   a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && !(cnt_en && slice_en)) |=> $stable(q));

endmodule

// File: rtl/casc_count.sv
`timescale 1ns/1ps
module casc_count #(
   parameter int STAGE_W   = 4,
   parameter int STAGES    = 2,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic                        clk,
   input  logic                        clr_n,
   input  logic                        load_n,
   input  logic                        cnt_en,
   input  logic                        carry_en,
   input  logic [STAGE_W*STAGES-1:0]   din,
   output logic [STAGE_W*STAGES-1:0]   q,
   output logic                        carry_out
);

   localparam int TW = STAGE_W * STAGES;

   generate
      if (TW > 64) begin : g_bad_total
         $error("casc_count: total width above 64 bits");
      end
   endgenerate

   logic [STAGES-1:0] term;
   logic [STAGES-1:0] slice_en;

   casc_carry #(
      .STAGES    (STAGES),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_carry (
      .carry_en  (carry_en),
      .term      (term),
      .slice_en  (slice_en),
      .carry_out (carry_out)
   );

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         casc_stage #(.W(STAGE_W)) u_stage (
            .clk      (clk),
            .clr_n    (clr_n),
            .load_n   (load_n),
            .cnt_en   (cnt_en),
            .slice_en (slice_en[k]),
            .din      (din[k*STAGE_W +: STAGE_W]),
            .q        (q[k*STAGE_W +: STAGE_W]),
            .term     (term[k])
         );
      end
   endgenerate

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= armed | ~clr_n;

   a_r6_carry_high: assert property (@(posedge clk) disable iff (!armed)
      carry_out |-> ((&q) && carry_en));
   a_r6_carry_gated: assert property (@(posedge clk) disable iff (!armed)
      (!carry_en) |-> !carry_out);
   a_r8_wide_step: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en && carry_en) |=> (q == TW'($past(q) + 1'b1)));
   a_r4_wrap: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en && carry_en && (&q)) |=> (q == '0));

endmodule

// File: tb/test_casc_count.sv
`timescale 1ns/1ps
module test_casc_count;

   localparam int SW = 4;
   localparam int NS = 2;
   localparam int TW = SW * NS;
   localparam logic [TW-1:0] ALL1 = {TW{1'b1}};

   logic clk = 1'b0;
   logic clr_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, carry_en = 1'b0;
   logic [TW-1:0] din = '0;
   logic [TW-1:0] q;
   logic carry_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [TW-1:0] exp_q = '0;
   bit known = 1'b0;

   always #5 clk = ~clk;

   casc_count #(.STAGE_W(SW), .STAGES(NS), .LOOKAHEAD(1'b1)) i_casc_count (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
      .carry_en(carry_en), .din(din), .q(q), .carry_out(carry_out)
   );

   task automatic chk(input string tag, input logic [TW-1:0] got, input logic [TW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [TW-1:0] model(input logic [TW-1:0] cur, input logic c,
                                           input logic l, input logic e, input logic t,
                                           input logic [TW-1:0] d);
      if (!c)          return '0;
      else if (!l)     return d;
      else if (e && t) return cur + 1'b1;
      else             return cur;
   endfunction

   // drive at the falling edge, check between edges, then after the rising edge
   task automatic apply(input logic c, input logic l, input logic e, input logic t,
                        input logic [TW-1:0] d, input string tag);
      string use_tag;
      @(negedge clk);
      clr_n = c; load_n = l; cnt_en = e; carry_en = t; din = d;
      #1;
      if (known) begin
         chk("R7 q steady between edges", q, exp_q);
         chk("R6 carry_out", {{(TW-1){1'b0}}, carry_out},
             {{(TW-1){1'b0}}, (exp_q == ALL1) && t});
      end
      exp_q = model(exp_q, c, l, e, t, d);
      known = 1'b1;
      if (tag != "")    use_tag = tag;
      else if (!c)      use_tag = "R1 clear";
      else if (!l)      use_tag = "R2 load";
      else if (e && t)  use_tag = "R3 count";
      else              use_tag = "R5 hold";
      @(posedge clk);
      #1;
      chk(use_tag, q, exp_q);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // reset state through the synchronous clear, all other controls active
      apply(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, "R1 clear beats load");
      chk("R6 carry idle after clear", {{(TW-1){1'b0}}, carry_out}, '0);

      // R10: preset near the top, count through the wrap, then freeze
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'hFC, "R10 preset");
      for (int i = 0; i < 6; i++) apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R10 count");
      chk("R10 final value", q, 8'h02);
      for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R10 frozen");

      // R6: carry follows carry_en with no edge
      apply(1'b1, 1'b0, 1'b0, 1'b0, ALL1, "R2 load all ones");
      @(negedge clk); carry_en = 1'b1; #1;
      chk("R6 carry rises without edge", {{(TW-1){1'b0}}, carry_out}, 8'h01);
      carry_en = 1'b0; #1;
      chk("R6 carry falls without edge", {{(TW-1){1'b0}}, carry_out}, 8'h00);

      // exhaustive: each value preset, then stepped under every enable pair
      for (int v = 0; v < (1 << TW); v++) begin
         for (int m = 0; m < 4; m++) begin
            apply(1'b1, 1'b0, m[0], m[1], v[TW-1:0], "R2 preset sweep");
            if (v == (1 << TW) - 1 && m == 3)
               apply(1'b1, 1'b1, 1'b1, 1'b1, '0, "R4 wrap to zero");
            else if (v[SW-1:0] == {SW{1'b1}} && m == 3)
               apply(1'b1, 1'b1, 1'b1, 1'b1, '0, "R8 slice boundary");
            else
               apply(1'b1, 1'b1, m[0], m[1], '0, "");
         end
      end

      // R9: terminal decode of 9 fed back into clear
      apply(1'b0, 1'b1, 1'b1, 1'b1, '0, "R1 clear");
      for (int i = 0; i < 30; i++)
         apply(q != 8'd9, 1'b1, 1'b1, 1'b1, '0, "R9 mod-10 loop");

      // random sequences against the priority model
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] r;
         r = 4'($urandom);
         apply(r[0] | r[1] | ($urandom_range(0, 3) != 0), r[2] | ($urandom_range(0, 2) != 0),
               r[3] | r[1], ($urandom_range(0, 4) != 0), TW'($urandom), "");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule